// File: doc/BRIEF.md
# I2C Target Front End for a Four-Channel Byte Converter

This block is the serial-bus side of a small data converter with four 8-bit input channels and one 8-bit output. It watches SCL and SDA with a fast system clock and resynchronizes both lines. It finds START, repeated START and STOP conditions and answers only to the 7-bit device address 1001000. SDA is never driven high. The block only pulls it low, through an output-enable that goes to an external open-drain pad.

A master writes a control byte that picks one input channel and can switch the output on. Any data bytes after it load the output register. To fetch a sample, the master writes the control byte, issues a repeated START, addresses the device for reading and clocks in one byte. The block then returns the current sample of the selected channel. Channel samples come in as parallel digital inputs, and the output code leaves as a parallel bus together with an enable flag.

Top module: `i2c_dac_target`

## Requirements
- R1: While reset is asserted, and right after it, the block drives no SDA pull-down (`sda_oe` = 0), and `out_active` = 0 and `out_code` = 0.
- R2: After a START, a first byte of 0x90 (address 1001000, bit 0 = 0 for write) is acknowledged: SDA is held low throughout SCL high in the ninth clock.
- R3: A first byte whose upper seven bits are not 1001000 is not acknowledged. Every byte after it is ignored, with no ACK and no register change, until the next START.
- R4: In a write, the byte after the address is the control byte. Its bits [1:0] select input channel 0..3 and its bit 6 is the output-enable. The control byte is acknowledged.
- R5: Every byte after the control byte in the same write is acknowledged and loads the output register, MSB first. When several bytes are sent, the last one stays.
- R6: `out_active` follows control bit 6. `out_code` shows the output register while `out_active` = 1 and is 0 otherwise. The register keeps its value while the output is disabled.
- R7: The sequence write address, control byte, repeated START, 0x91 (address with read bit 1) is acknowledged. The block then shifts out, MSB first, the sample of the channel selected by control bits [1:0], captured at the read-address ACK.
- R8: When the master does not acknowledge a read byte, the block releases SDA and keeps it released through the following STOP.
- R9: A STOP or START in the middle of a byte abandons that byte: nothing is stored. After a START the bit count restarts, so a complete transaction right after it works normally.
- R10: `sda_oe`, `out_active` and `out_code` change only while the synchronized SCL is low. A STOP always leaves SDA released on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | SCL line level from the pad |
| sda_in | input | 1 | SDA line level from the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| ch_samples | input | 32 | Four 8-bit channel samples, channel n in bits [8n+7:8n] |
| out_code | output | 8 | Output code, 0 while the output is disabled |
| out_active | output | 1 | Output-enable bit from the control register |

## Verification
On every cycle the assertions check four things. The quiet state after reset holds, and the SDA pull-down and both output fields only move while the synchronized SCL is low. A STOP always releases SDA, and a nonzero output code never appears while the output is disabled. The bench's scenarios are the only place that shows what the bus transfers mean. They cover which addresses get an ACK, which channel a read returns and in which bit order, which byte stays in the output register after a burst, and that an abandoned byte or an unmatched address leaves the registers unchanged.

// File: rtl/i2c_tgt_pkg.sv
// Package: shared state encoding for the I2C target engine.
// Assumes one transfer at a time; states cover address, control, write and read phases.
package i2c_tgt_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } tgt_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
// Module: resynchronizes one open-drain bus line into the clk domain and keeps
// the previous synchronized level for edge detection.
// Assumes the line idles high, so every stage resets to 1.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic level,
    output logic level_prev
);
    logic [STAGES-1:0] chain;

    // first stage samples the raw pin
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b1;
        else        chain[0] <= line_in;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            // each further stage resamples the one before it
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b1;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    // one extra copy of the synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) level_prev <= 1'b1;
        else        level_prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
endmodule

// File: rtl/i2c_tgt_regs.sv
// Module: control register (channel select and output enable), output-code
// register and the channel sample multiplexer.
// Assumes write strobes are single-cycle pulses from the engine.
module i2c_tgt_regs #(
    parameter int DATA_W = 8,
    parameter int NUM_CH = 4,
    parameter int OE_BIT = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ctrl_we,
    input  logic                     data_we,
    input  logic [DATA_W-1:0]        wbyte,
    input  logic [NUM_CH*DATA_W-1:0] samples,
    output logic [DATA_W-1:0]        sel_sample,
    output logic [DATA_W-1:0]        out_code,
    output logic                     out_active
);
    localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [SEL_W-1:0]  ch_sel;
    logic              oe_q;
    logic [DATA_W-1:0] code_q;
    logic [DATA_W-1:0] ch_word [NUM_CH];

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            assign ch_word[g] = samples[g*DATA_W +: DATA_W];
        end
    endgenerate

    // control fields are loaded from a completed control byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_sel <= '0;
            oe_q   <= 1'b0;
        end else if (ctrl_we) begin
            ch_sel <= wbyte[SEL_W-1:0];
            oe_q   <= wbyte[OE_BIT];
        end
    end

    // output code register takes every completed data byte
    always_ff @(posedge clk) begin
        if (!rst_n)       code_q <= '0;
        else if (data_we) code_q <= wbyte;
    end

    assign sel_sample = ch_word[ch_sel];
    assign out_active = oe_q;
    assign out_code   = oe_q ? code_q : '0;
endmodule

// File: rtl/i2c_tgt_engine.sv
// Module: bus protocol engine. It shifts bytes in and out on synchronized SCL
// edges, checks the device address, drives ACK and read bits through sda_oe,
// and pulses write strobes for the control and data bytes.
// Assumes DATA_W = ADDR_W + 1 and that a START or STOP outranks any SCL edge.
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter int              ADDR_W   = 7,
    parameter int              DATA_W   = 8,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 7'b1001000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [DATA_W-1:0] sel_sample,
    output logic              sda_oe,
    output logic              ctrl_we,
    output logic              data_we,
    output logic [DATA_W-1:0] wbyte
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

    tgt_state_t        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shreg;
    logic              rw_bit;
    logic              master_ack;
    logic              byte_done;

    assign byte_done = scl_fall && (bit_cnt == FULL) && !start_det && !stop_det;
    assign ctrl_we   = byte_done && (state == ST_CTRL);
    assign data_we   = byte_done && (state == ST_WDATA);
    assign wbyte     = shreg;

    // protocol sequencer: bus conditions first, then SCL edges per state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            rw_bit     <= 1'b0;
            master_ack <= 1'b0;
            sda_oe     <= 1'b0;
        end else if (start_det) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_CTRL, ST_WDATA: begin
                    if (scl_rise && bit_cnt < FULL) begin
                        shreg   <= {shreg[DATA_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (byte_done) begin
                        bit_cnt <= '0;
                        if (state == ST_ADDR) begin
                            if (shreg[DATA_W-1 -: ADDR_W] == DEV_ADDR) begin
                                state  <= ST_ADDR_ACK;
                                rw_bit <= shreg[0];
                                sda_oe <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (state == ST_CTRL) begin
                            state  <= ST_CTRL_ACK;
                            sda_oe <= 1'b1;
                        end else begin
                            state  <= ST_WDATA_ACK;
                            sda_oe <= 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (rw_bit) begin
                            shreg  <= sel_sample;
                            sda_oe <= ~sel_sample[DATA_W-1];
                            state  <= ST_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_CTRL;
                        end
                    end
                end
                ST_CTRL_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise && bit_cnt < FULL) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall && bit_cnt == FULL) begin
                        bit_cnt <= '0;
                        sda_oe  <= 1'b0;
                        state   <= ST_RDATA_ACK;
                    end else if (scl_fall && bit_cnt != '0) begin
                        shreg  <= {shreg[DATA_W-2:0], 1'b0};
                        sda_oe <= ~shreg[DATA_W-2];
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_rise) begin
                        master_ack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (master_ack) begin
                            shreg  <= sel_sample;
                            sda_oe <= ~sel_sample[DATA_W-1];
                            state  <= ST_RDATA;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/i2c_dac_target.sv
// Module: top of the I2C target for a four-input, one-output byte converter.
// Synchronizes both bus lines, derives START/STOP and SCL edges, and joins the
// protocol engine to the register block. SDA is open-drain through sda_oe.
module i2c_dac_target #(
    parameter int              ADDR_W      = 7,
    parameter int              DATA_W      = 8,
    parameter int              NUM_CH      = 4,
    parameter int              OE_BIT      = 6,
    parameter int              SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] DEV_ADDR  = 7'b1001000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_in,
    input  logic                     sda_in,
    output logic                     sda_oe,
    input  logic [NUM_CH*DATA_W-1:0] ch_samples,
    output logic [DATA_W-1:0]        out_code,
    output logic                     out_active
);
    logic scl_s, scl_p, sda_s, sda_p;
    logic scl_rise, scl_fall, start_det, stop_det;
    logic ctrl_we, data_we;
    logic [DATA_W-1:0] wbyte, sel_sample;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_in(scl_in), .level(scl_s), .level_prev(scl_p)
    );
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_in(sda_in), .level(sda_s), .level_prev(sda_p)
    );

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

    i2c_tgt_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_ADDR(DEV_ADDR)) u_engine (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .sel_sample(sel_sample), .sda_oe(sda_oe),
        .ctrl_we(ctrl_we), .data_we(data_we), .wbyte(wbyte)
    );

    i2c_tgt_regs #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .OE_BIT(OE_BIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .data_we(data_we),
        .wbyte(wbyte), .samples(ch_samples), .sel_sample(sel_sample),
        .out_code(out_code), .out_active(out_active)
    );
endmodule

// File: rtl/i2c_dac_target_chk.sv
// Checker: cycle-level properties of the I2C target, bound to the top module.
module i2c_dac_target_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              stop_det,
    input logic              sda_oe,
    input logic              out_active,
    input logic [DATA_W-1:0] out_code
);
    // R1: reset leaves the bus released and the output cleared
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!sda_oe && !out_active && out_code == '0));

    // R10: the SDA pull-down only moves while synchronized SCL is low
    a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    // R10: a STOP always releases SDA on the next cycle
    a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R4: the enable bit is only written while SCL is low
    a_r4_enable_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (out_active != $past(out_active)) |-> !scl_s);

    // R5: the output code only changes while SCL is low
    a_r5_code_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (out_code != $past(out_code)) |-> !scl_s);

    // R6: a nonzero code never appears with the output disabled
    a_r6_code_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_code != '0) |-> out_active);
endmodule

bind i2c_dac_target i2c_dac_target_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
    .sda_oe(sda_oe), .out_active(out_active), .out_code(out_code)
);

// File: tb/i2c_dac_target_bench.sv
// Directed bench: a bus-master model drives SCL/SDA, an open-drain SDA line
// combines the master with sda_oe, and each scenario task checks its results.
module i2c_dac_target_bench;
    localparam int Q = 20;  // quarter SCL period in clk cycles

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic [31:0] samples = {8'h3C, 8'h81, 8'h5E, 8'hC3};
    logic        sda_oe;
    logic [7:0]  out_code;
    logic        out_active;
    logic        sda_line;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          finished = 1'b0;

    assign sda_line = m_sda & ~sda_oe;

    always #5 clk = ~clk;

    i2c_dac_target u_i2c_dac_target (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .sda_oe(sda_oe), .ch_samples(samples),
        .out_code(out_code), .out_active(out_active)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    // send nbits of b MSB first; if nbits is 8 also clock the ACK bit
    task automatic send_bits(input logic [7:0] b, input int nbits, output bit acked);
        bit early, late;
        for (int i = 7; i > 7 - nbits; i--) begin
            m_sda = b[i]; tick(Q);
            m_scl = 1'b1; tick(2*Q);
            m_scl = 1'b0; tick(Q);
        end
        acked = 1'b0;
        if (nbits == 8) begin
            m_sda = 1'b1; tick(Q);
            m_scl = 1'b1; tick(2);
            early = ~sda_line;
            tick(2*Q - 4);
            late = ~sda_line;
            tick(2);
            m_scl = 1'b0; tick(Q);
            acked = early & late;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8, acked);
    endtask

    task automatic read_byte(input bit give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            m_scl = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            m_scl = 1'b0; tick(Q);
        end
        m_sda = give_ack ? 1'b0 : 1'b1; tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_scl = 1'b0; tick(Q);
        m_sda = 1'b1;
    endtask

    task automatic t_reset();
        check(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
        check(out_active == 1'b0, "R1 out_active after reset", out_active, 0);
        check(out_code == 8'h00, "R1 out_code after reset", out_code, 0);
    endtask

    task automatic t_write_single();
        bit a;
        bus_start();
        send_byte(8'h90, a); check(a, "R2 address ACK", a, 1);
        send_byte(8'h40, a); check(a, "R4 control ACK", a, 1);
        send_byte(8'hA5, a); check(a, "R5 data ACK", a, 1);
        bus_stop();
        check(out_active == 1'b1, "R4 enable bit 6", out_active, 1);
        check(out_code == 8'hA5, "R5 output code", out_code, 8'hA5);
        check(sda_oe == 1'b0, "R10 released after stop", sda_oe, 0);
    endtask

    task automatic t_write_burst();
        bit a1, a2;
        bus_start();
        send_byte(8'h90, a1);
        send_byte(8'h40, a1);
        send_byte(8'h12, a1);
        send_byte(8'h34, a2);
        bus_stop();
        check(a1 && a2, "R5 burst bytes ACKed", {a1, a2}, 3);
        check(out_code == 8'h34, "R5 last byte kept", out_code, 8'h34);
    endtask

    task automatic t_disable_gate();
        bit a;
        bus_start();
        send_byte(8'h90, a);
        send_byte(8'h00, a);
        send_byte(8'h77, a);
        bus_stop();
        check(out_active == 1'b0, "R6 disabled flag", out_active, 0);
        check(out_code == 8'h00, "R6 code gated while disabled", out_code, 0);
        bus_start();
        send_byte(8'h90, a);
        send_byte(8'h40, a);
        bus_stop();
        check(out_code == 8'h77, "R6 register kept while disabled", out_code, 8'h77);
    endtask

    task automatic t_wrong_address();
        bit a;
        bus_start();
        send_byte(8'h94, a); check(!a, "R3 foreign address not ACKed", a, 0);
        send_byte(8'h03, a); check(!a, "R3 following byte ignored", a, 0);
        send_byte(8'h99, a);
        bus_stop();
        check(out_active == 1'b1 && out_code == 8'h77, "R3 registers unchanged",
              {out_active, out_code}, {1'b1, 8'h77});
    endtask

    task automatic t_read(input logic [7:0] ctrl, input logic [7:0] exp);
        bit a;
        logic [7:0] got;
        bus_start();
        send_byte(8'h90, a);
        send_byte(ctrl, a);
        bus_start();
        send_byte(8'h91, a); check(a, "R7 read address ACK", a, 1);
        read_byte(1'b0, got);
        check(got == exp, "R7 channel sample", got, exp);
        check(sda_oe == 1'b0, "R8 SDA released after NACK", sda_oe, 0);
        bus_stop();
        check(sda_oe == 1'b0, "R8 SDA released through STOP", sda_oe, 0);
    endtask

    task automatic t_abort();
        bit a;
        bus_start();
        send_byte(8'h90, a);
        send_byte(8'h40, a);
        send_byte(8'h5A, a);
        bus_stop();
        bus_start();
        send_byte(8'h90, a);
        send_byte(8'h40, a);
        send_bits(8'hFF, 3, a);
        bus_stop();
        check(out_code == 8'h5A, "R9 partial byte before STOP dropped", out_code, 8'h5A);
        bus_start();
        send_byte(8'h90, a);
        send_byte(8'h40, a);
        send_bits(8'hC0, 4, a);
        bus_start();
        send_byte(8'h90, a); check(a, "R9 address ACK after mid-byte START", a, 1);
        send_byte(8'h40, a);
        send_byte(8'h66, a);
        bus_stop();
        check(out_code == 8'h66, "R9 transaction after mid-byte START", out_code, 8'h66);
    endtask

    initial begin
        tick(5);
        t_reset();
        rst_n = 1'b1;
        tick(5);
        t_write_single();
        t_write_burst();
        t_disable_gate();
        t_wrong_address();
        t_read(8'h00, 8'hC3);
        t_read(8'h01, 8'h5E);
        t_read(8'h02, 8'h81);
        t_read(8'h03, 8'h3C);
        t_abort();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule